// File: doc/BRIEF.md
# Lane Source Select and Delay

This block sits at the head of an eight-lane sampling datapath. For every lane it picks one of four sources: the live digitizer byte, one of two pseudo-random noise generators, or a constant zero. It then holds the picked byte back by a programmable number of whole clock cycles. Host software programs three 32-bit words (source codes, delays and seeds) with four bits of code and four bits of delay per lane. It pulses an arm line to restart both noise generators from known seeds, so that several such blocks produce the same noise sequence.

Each noise generator is a 16-bit maximal-length shift register that advances once per clock. Its low byte is the noise sample. The arm event reloads each generator from its own seed byte. The delay for each lane is a tap on a 16-entry history of the picked bytes. A new delay value therefore takes effect at once and shows history that is already stored.

Top module: `lane_source_delay`

## Requirements
- R1: Lane i takes its source code from src_sel bits [4i+3:4i]. Code 0 picks the digitizer byte adc_lanes[8i+7:8i].
- R2: Code 1 picks bits [7:0] of noise generator 0. Code 2 picks bits [7:0] of noise generator 1.
- R3: Codes 3 through 15 pick the constant byte 8'h00.
- R4: With d = dly_sel bits [4i+3:4i], lane_out[8i+7:8i] equals the byte that lane i picked at the clock edge d edges before the latest edge, which is d+1 edges of latency. The tap is selected combinationally, so a change of d takes effect without waiting for an edge.
- R5: Each generator is a 16-bit register that moves at every clock edge without an arm event from s to {s[14:0], s[15]^s[13]^s[12]^s[10]}. After reset it holds 16'h0001.
- R6: An arm event is a clock edge where arm is 1 and was 0 at the previous edge. On that edge generator g loads {8'h00, seed_word[8g+7:8g]}. Holding arm at 1 does not reload, and a seed_word change has no effect until the next arm event.
- R7: A seed byte of 8'h00 loads 16'h0001. Seed bytes 2 and 3 (seed_word[31:16]) are not used.
- R8: While rst is high at an edge, all history and all outputs are cleared to 8'h00, the generators return to 16'h0001 and the arm history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adc_lanes | input | 64 | Eight digitizer bytes, lane i at [8i+7:8i] |
| src_sel | input | 32 | Source code nibble per lane |
| dly_sel | input | 32 | Delay nibble per lane |
| seed_word | input | 32 | Seed byte per noise generator |
| arm | input | 1 | Level whose rising edge reloads the generators |
| lane_out | output | 64 | Eight delayed output bytes, lane i at [8i+7:8i] |

## Verification
A wrong generator state shows at every lane coded 1 or 2 after that lane's delay, from one to sixteen cycles later. It then stays wrong, because the register never recovers without another arm event. A missed or repeated seed load shows as a sequence that is offset from the bench model's sequence on the first noise sample after the arm edge. A corrupted history entry shows only while a lane's delay tap points at it. For that reason the bench changes delay values over held history and sweeps the full delay range.

// File: rtl/lane_source_delay_pkg.sv
package lane_source_delay_pkg;

  localparam int LFSR_W   = 16;
  localparam int SAMPLE_W = 8;

  // Source codes held in each select nibble
  typedef enum logic [3:0] {
    SRC_ADC     = 4'd0,
    SRC_NOISE_A = 4'd1,
    SRC_NOISE_B = 4'd2,
    SRC_ZERO    = 4'd3
  } src_code_e;

  // One step of the maximal-length register, taps 16,14,13,11
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // Seed byte to full register value; a zero seed is replaced
  function automatic logic [LFSR_W-1:0] seed_to_state(input logic [SAMPLE_W-1:0] b);
    logic [LFSR_W-1:0] v;
    v = {{(LFSR_W-SAMPLE_W){1'b0}}, b};
    if (b == '0) v = {{(LFSR_W-1){1'b0}}, 1'b1};
    return v;
  endfunction

  // Value after reset, identical to the zero-seed replacement
  function automatic logic [LFSR_W-1:0] idle_state();
    return {{(LFSR_W-1){1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/lsd_noise_gen.sv
module lsd_noise_gen
  import lane_source_delay_pkg::*;
#(
  parameter int SEED_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [SEED_W-1:0] seed_byte,
  output logic [LFSR_W-1:0] state,
  output logic [SAMPLE_W-1:0] sample
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;

  always_comb begin
    if (load_en) state_d = seed_to_state(seed_byte);
    else         state_d = lfsr_advance(state_q);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= idle_state();
    else     state_q <= state_d;
  end

  assign state  = state_q;
  assign sample = state_q[SAMPLE_W-1:0];

endmodule

// File: rtl/lsd_lane.sv
module lsd_lane
  import lane_source_delay_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int DLY_W   = 4,
  parameter int NUM_GEN = 2,
  localparam int DEPTH  = 1 << DLY_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CODE_W-1:0]            code,
  input  logic [DLY_W-1:0]             dly,
  input  logic [SAMPLE_W-1:0]          adc,
  input  logic [NUM_GEN*SAMPLE_W-1:0]  noise_flat,
  output logic [SAMPLE_W-1:0]          pick,
  output logic [SAMPLE_W-1:0]          out
);

  logic [SAMPLE_W-1:0] hist_q [DEPTH];

  // Source multiplexer: code 0 = digitizer, 1..NUM_GEN = generators, rest zero
  always_comb begin
    pick = '0;
    if (code == CODE_W'(SRC_ADC)) pick = adc;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (code == CODE_W'(g + 1)) pick = noise_flat[g*SAMPLE_W +: SAMPLE_W];
    end
  end

  // History shift register; entry k holds the pick from k edges ago
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) hist_q[k] <= '0;
    end else begin
      hist_q[0] <= pick;
      for (int k = 1; k < DEPTH; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  assign out = hist_q[dly];

endmodule

// File: rtl/lane_source_delay.sv
module lane_source_delay
  import lane_source_delay_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int CODE_W    = 4,
  parameter int DLY_W     = 4,
  parameter int NUM_GEN   = 2,
  parameter int SEED_SLOTS = 4,
  localparam int LANE_W   = NUM_LANES * SAMPLE_W,
  localparam int SEL_W    = NUM_LANES * CODE_W,
  localparam int DSEL_W   = NUM_LANES * DLY_W,
  localparam int SEEDW_W  = SEED_SLOTS * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] adc_lanes,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [DSEL_W-1:0] dly_sel,
  input  logic [SEEDW_W-1:0] seed_word,
  input  logic              arm,
  output logic [LANE_W-1:0] lane_out
);

  // Named internal events for the checker
  logic                          arm_q;
  logic                          arm_evt;
  logic [NUM_GEN*LFSR_W-1:0]     gen_state_flat;
  logic [NUM_GEN*SAMPLE_W-1:0]   noise_flat;
  logic [LANE_W-1:0]             pick_flat;

  // Arm rising-edge detector
  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= arm;
  end
  assign arm_evt = arm & ~arm_q;

  // Noise generators, one seed byte each
  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_noise
    lsd_noise_gen #(.SEED_W(SAMPLE_W)) noise_i (
      .clk       (clk),
      .rst       (rst),
      .load_en   (arm_evt),
      .seed_byte (seed_word[g*SAMPLE_W +: SAMPLE_W]),
      .state     (gen_state_flat[g*LFSR_W +: LFSR_W]),
      .sample    (noise_flat[g*SAMPLE_W +: SAMPLE_W])
    );
  end

  // Per-lane select and delay paths
  for (genvar i = 0; i < NUM_LANES; i++) begin : gen_lane
    lsd_lane #(
      .CODE_W  (CODE_W),
      .DLY_W   (DLY_W),
      .NUM_GEN (NUM_GEN)
    ) lane_i (
      .clk        (clk),
      .rst        (rst),
      .code       (src_sel[i*CODE_W +: CODE_W]),
      .dly        (dly_sel[i*DLY_W +: DLY_W]),
      .adc        (adc_lanes[i*SAMPLE_W +: SAMPLE_W]),
      .noise_flat (noise_flat),
      .pick       (pick_flat[i*SAMPLE_W +: SAMPLE_W]),
      .out        (lane_out[i*SAMPLE_W +: SAMPLE_W])
    );
  end

endmodule

// File: rtl/lane_source_delay_chk.sv
module lane_source_delay_chk
  import lane_source_delay_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int CODE_W    = 4,
  parameter int DLY_W     = 4,
  parameter int NUM_GEN   = 2,
  parameter int SEED_SLOTS = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_LANES*SAMPLE_W-1:0]   adc_lanes,
  input logic [NUM_LANES*CODE_W-1:0]     src_sel,
  input logic [NUM_LANES*DLY_W-1:0]      dly_sel,
  input logic [SEED_SLOTS*SAMPLE_W-1:0]  seed_word,
  input logic [NUM_LANES*SAMPLE_W-1:0]   lane_out,
  input logic [NUM_LANES*SAMPLE_W-1:0]   pick_flat,
  input logic [NUM_GEN*LFSR_W-1:0]       gen_state_flat,
  input logic                            arm_evt
);

  logic live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : gen_lane_chk
    AST_ZERO_DELAY_FOLLOWS_PICK: assert property (@(posedge clk) disable iff (rst)
      (live_q && dly_sel[i*DLY_W +: DLY_W] == '0) |->
        lane_out[i*SAMPLE_W +: SAMPLE_W] == $past(pick_flat[i*SAMPLE_W +: SAMPLE_W])); // R4
    AST_ADC_PASSTHROUGH: assert property (@(posedge clk) disable iff (rst)
      (live_q && dly_sel[i*DLY_W +: DLY_W] == '0 && $past(src_sel[i*CODE_W +: CODE_W]) == '0) |->
        lane_out[i*SAMPLE_W +: SAMPLE_W] == $past(adc_lanes[i*SAMPLE_W +: SAMPLE_W])); // R1
    AST_HIGH_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
      (live_q && dly_sel[i*DLY_W +: DLY_W] == '0 && $past(src_sel[i*CODE_W +: CODE_W]) >= CODE_W'(3)) |->
        lane_out[i*SAMPLE_W +: SAMPLE_W] == '0); // R3
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : gen_gen_chk
    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
      gen_state_flat[g*LFSR_W +: LFSR_W] != '0); // R7
    AST_GEN_SHIFTS: assert property (@(posedge clk) disable iff (rst)
      (!rst && !arm_evt) |=>
        gen_state_flat[g*LFSR_W+1 +: LFSR_W-1] == $past(gen_state_flat[g*LFSR_W +: LFSR_W-1])); // R5
    AST_SEED_LOADED: assert property (@(posedge clk) disable iff (rst)
      (!rst && arm_evt && seed_word[g*SAMPLE_W +: SAMPLE_W] != '0) |=>
        gen_state_flat[g*LFSR_W +: LFSR_W] ==
          {{(LFSR_W-SAMPLE_W){1'b0}}, $past(seed_word[g*SAMPLE_W +: SAMPLE_W])}); // R6
    AST_ZERO_SEED_SUBST: assert property (@(posedge clk) disable iff (rst)
      (!rst && arm_evt && seed_word[g*SAMPLE_W +: SAMPLE_W] == '0) |=>
        gen_state_flat[g*LFSR_W +: LFSR_W] == LFSR_W'(1)); // R7
  end

endmodule

bind lane_source_delay lane_source_delay_chk #(
  .NUM_LANES  (NUM_LANES),
  .CODE_W     (CODE_W),
  .DLY_W      (DLY_W),
  .NUM_GEN    (NUM_GEN),
  .SEED_SLOTS (SEED_SLOTS)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .adc_lanes      (adc_lanes),
  .src_sel        (src_sel),
  .dly_sel        (dly_sel),
  .seed_word      (seed_word),
  .lane_out       (lane_out),
  .pick_flat      (pick_flat),
  .gen_state_flat (gen_state_flat),
  .arm_evt        (arm_evt)
);

// File: tb/lane_source_delay_tb_top.sv
`timescale 1ns/1ps
module lane_source_delay_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] adc_lanes;
  logic [31:0] src_sel;
  logic [31:0] dly_sel;
  logic [31:0] seed_word;
  logic        arm;
  logic [63:0] lane_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Bench model state
  logic [7:0]  m_hist [8][16];
  logic [15:0] m_gen  [2];
  logic        m_arm_prev;

  always #2 clk = ~clk;

  lane_source_delay dut_i (
    .clk       (clk),
    .rst       (rst),
    .adc_lanes (adc_lanes),
    .src_sel   (src_sel),
    .dly_sel   (dly_sel),
    .seed_word (seed_word),
    .arm       (arm),
    .lane_out  (lane_out)
  );

  // Feedback as parity of the tap mask 0xB400 (bits 15,13,12,10)
  function automatic logic [15:0] m_step(input logic [15:0] s);
    return (s << 1) | 16'(^(s & 16'hB400));
  endfunction

  function automatic logic [15:0] m_load(input logic [7:0] b);
    return (b == 8'd0) ? 16'd1 : {8'd0, b};
  endfunction

  function automatic logic [7:0] m_pick(input int lane);
    logic [3:0] c;
    c = src_sel[lane*4 +: 4];
    case (c)
      4'd0:    return adc_lanes[lane*8 +: 8];
      4'd1:    return m_gen[0][7:0];
      4'd2:    return m_gen[1][7:0];
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_edge();
    logic [7:0] p [8];
    if (rst) begin
      for (int l = 0; l < 8; l++) for (int k = 0; k < 16; k++) m_hist[l][k] = 8'd0;
      m_gen[0] = 16'd1;
      m_gen[1] = 16'd1;
      m_arm_prev = 1'b0;
    end else begin
      for (int l = 0; l < 8; l++) p[l] = m_pick(l);
      for (int l = 0; l < 8; l++) begin
        for (int k = 15; k > 0; k--) m_hist[l][k] = m_hist[l][k-1];
        m_hist[l][0] = p[l];
      end
      for (int g = 0; g < 2; g++) begin
        if (arm && !m_arm_prev) m_gen[g] = m_load(seed_word[g*8 +: 8]);
        else                    m_gen[g] = m_step(m_gen[g]);
      end
      m_arm_prev = arm;
    end
  endtask

  task automatic check_lanes(input string tag);
    for (int l = 0; l < 8; l++) begin
      logic [7:0] exp_v;
      exp_v = m_hist[l][dly_sel[l*4 +: 4]];
      n_checks++;
      if (lane_out[l*8 +: 8] !== exp_v) begin
        n_fail++;
        $display("FAIL %s lane %0d: actual %h expected %h", tag, l, lane_out[l*8 +: 8], exp_v);
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_lanes(tag);
  endtask

  task automatic rand_adc();
    adc_lanes = {$urandom(), $urandom()};
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; arm = 1'b0;
    adc_lanes = '0; src_sel = '0; dly_sel = '0; seed_word = '0;
    // R8: reset state
    repeat (3) step("R8");

    rst = 1'b0;
    // R1: digitizer pass-through, zero delay, random data
    src_sel = 32'h0000_0000;
    for (int n = 0; n < 20; n++) begin rand_adc(); step("R1"); end

    // R5: free-running generators from reset value, codes 1 and 2
    src_sel = 32'h2121_2121;
    for (int n = 0; n < 40; n++) begin rand_adc(); step("R5"); end

    // R6: seed and arm, then hold arm high, then change seed without arm
    seed_word = 32'h00_00_5A_C3;
    arm = 1'b1; step("R6");
    for (int n = 0; n < 10; n++) step("R6");
    seed_word = 32'h77_66_11_22;
    for (int n = 0; n < 10; n++) step("R6");
    arm = 1'b0;
    for (int n = 0; n < 10; n++) step("R6");

    // R7: zero seed bytes and unused upper bytes
    seed_word = 32'hFFEE_0000;
    arm = 1'b1; step("R7");
    arm = 1'b0;
    for (int n = 0; n < 20; n++) step("R7");
    seed_word = 32'h0000_0000;
    arm = 1'b1; step("R7");
    arm = 1'b0;
    for (int n = 0; n < 10; n++) step("R7");

    // R2: mixed generator codes, generator 1 seeded differently
    seed_word = 32'h0000_9D04;
    arm = 1'b1; step("R2");
    arm = 1'b0;
    src_sel = 32'h1221_2112;
    for (int n = 0; n < 20; n++) begin rand_adc(); step("R2"); end

    // R3: codes 3..15 all give zero
    src_sel = 32'hFEDC_BA93;
    for (int n = 0; n < 10; n++) begin rand_adc(); step("R3"); end
    src_sel = 32'h4567_8333;
    for (int n = 0; n < 10; n++) begin rand_adc(); step("R3"); end

    // R4: ramp with full delay, then retap held history
    src_sel = 32'h0000_0000;
    dly_sel = 32'hFFFF_FFFF;
    for (int n = 0; n < 24; n++) begin
      adc_lanes = {8{8'(n)}} ^ 64'h0706_0504_0302_0100;
      step("R4");
    end
    dly_sel = 32'h7654_3210;
    for (int n = 0; n < 4; n++) step("R4");
    dly_sel = 32'h0F1E_2D3C;
    for (int n = 0; n < 4; n++) step("R4");

    // R8: reset mid-run clears history and generators
    rst = 1'b1; step("R8"); step("R8");
    rst = 1'b0;
    src_sel = 32'h2121_2121; dly_sel = 32'h0000_0000;
    for (int n = 0; n < 10; n++) step("R8");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      rand_adc();
      if ($urandom_range(0, 15) == 0) src_sel = $urandom();
      else if ($urandom_range(0, 7) == 0) src_sel = {8{4'($urandom_range(0, 3))}};
      if ($urandom_range(0, 11) == 0) dly_sel = $urandom();
      if ($urandom_range(0, 19) == 0) begin
        seed_word = $urandom();
        if ($urandom_range(0, 2) == 0) seed_word[7:0] = 8'd0;
      end
      if ($urandom_range(0, 9) == 0) arm = ~arm;
      step("RND R1/R2/R3/R4/R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule